// File: doc/BRIEF.md
# Reseeding LFSR Self-Test Controller

This block drives a built-in self-test of a combinational unit. A pulse on the start input begins a run. The controller then walks through a seed table fixed at elaboration time. For each entry it spends one cycle loading the seed into a pattern LFSR. It then applies a fixed number of pseudorandom patterns to the unit. Two cascaded counters govern this. A seed index chooses the table entry, and a pattern counter measures the time spent on that entry and moves the run on to the next seed when it expires. Restarting the generator from several stored points reaches faults that one long pseudorandom sequence would miss.

The unit's response is sampled on every cycle that carries a valid pattern. It is reduced to the compactor width by XOR-folding and then shifted into a multiple-input signature register. After the final pattern of the final seed, the register is compared with a golden value given as a parameter. Done is then raised together with either pass or fail. The seed table, the patterns per seed, both feedback polynomials, the compactor width (1, 2, 4 or 8 bits) and the golden signature are all parameters.

Top module: `bist_reseed_ctrl`

## Requirements
- R1: A start accepted while idle begins a run. The run has one load cycle per seed, with pat_vld_o low, followed by PATS_PER_SEED cycles with pat_vld_o high. Seeds are used in table order starting at index 0, where entry i sits at SEED_TAB[i*PAT_W +: PAT_W].
- R2: The first pattern after a load equals the loaded seed. Each following pattern p' is derived from the previous pattern p as {p[PAT_W-2:0], ^(p & PAT_POLY)}.
- R3: A table entry of all zeros is loaded as all ones, so a zero pattern is never applied.
- R4: The signature is cleared when a run starts. On each valid-pattern cycle it becomes {s[SIG_W-2:0], ^(s & SIG_POLY)} XOR f, where f is the XOR of all SIG_W-bit slices of rsp_i. For SIG_W = 1 it becomes (^(s & SIG_POLY)) XOR f. Load cycles leave the signature unchanged.
- R5: One cycle after the last valid pattern, done_o rises. At that point pass_o is 1 exactly when the final signature equals GOLDEN, and fail_o is its complement. Done, pass and fail hold until the next accepted start, which clears all three.
- R6: A start pulse during a run, whether in a load or a pattern cycle, has no effect on the pattern sequence or on the result.
- R7: A synchronous reset aborts any run. On the next edge pat_vld_o, done_o, pass_o and fail_o are all 0, and the block waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Run request, acted on only while idle |
| rsp_i | input | RSP_W | Response from the unit under test |
| pat_o | output | PAT_W | Pattern applied to the unit under test |
| pat_vld_o | output | 1 | pat_o holds a pattern whose response is captured |
| done_o | output | 1 | Run complete |
| pass_o | output | 1 | Signature matched the golden value |
| fail_o | output | 1 | Signature differed from the golden value |

## Verification
The bench predicts every cycle of a run and compares it with the outputs: where the load gaps fall, the LFSR sequence after each reseed, and the substitute value used for the zero seed. An off-by-one in the pattern counter would show up as a shifted gap. A zero seed that is not replaced would produce a frozen all-zero pattern. A response captured during a load cycle would change the signature and turn pass into fail. The bench also flips a single response bit to force a mismatch, and then runs a clean pass again. A signature left over from the previous run would fail that second run. Start pulses placed inside a pattern cycle and inside a load cycle would, on a design that honoured them, restart the sequence. A mid-run reset must leave the block idle, with no status left asserted.

// File: rtl/bist_reseed_ctrl.sv
module bist_reseed_ctrl #(
  parameter int PAT_W         = 8,
  parameter int RSP_W         = 8,
  parameter int SIG_W         = 8,
  parameter int N_SEEDS       = 4,
  parameter int PATS_PER_SEED = 16,
  parameter logic [PAT_W-1:0]         PAT_POLY = PAT_W'(8'hB8),
  parameter logic [SIG_W-1:0]         SIG_POLY = SIG_W'(8'h8E),
  parameter logic [N_SEEDS*PAT_W-1:0] SEED_TAB = (N_SEEDS*PAT_W)'(32'h5A00C301),
  parameter logic [SIG_W-1:0]         GOLDEN   = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [RSP_W-1:0] rsp_i,
  output logic [PAT_W-1:0] pat_o,
  output logic             pat_vld_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o
);
  localparam int SEED_AW = (N_SEEDS > 1) ? $clog2(N_SEEDS) : 1;
  localparam int CNT_W   = (PATS_PER_SEED > 1) ? $clog2(PATS_PER_SEED) : 1;
  localparam int FOLD_N  = RSP_W / SIG_W;
  localparam logic [SEED_AW-1:0] LAST_SEED = SEED_AW'(N_SEEDS - 1);
  localparam logic [CNT_W-1:0]   LAST_PAT  = CNT_W'(PATS_PER_SEED - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} state_t;

  state_t             state;
  logic [SEED_AW-1:0] seed_idx;
  logic [CNT_W-1:0]   pat_cnt;
  logic [PAT_W-1:0]   lfsr, lfsr_nxt, seed_raw, seed_fix;
  logic [SIG_W-1:0]   sig, sig_nxt, rsp_fold;
  logic               done_q, match_q, seed_rd;

  assign seed_rd  = (state == S_LOAD);
  assign seed_raw = SEED_TAB[seed_idx*PAT_W +: PAT_W];
  assign seed_fix = (seed_raw == '0) ? '1 : seed_raw;
  assign lfsr_nxt = {lfsr[PAT_W-2:0], ^(lfsr & PAT_POLY)};

  always_comb begin
    rsp_fold = '0;
    for (int i = 0; i < FOLD_N; i++) rsp_fold ^= rsp_i[i*SIG_W +: SIG_W];
  end

  generate
    if (SIG_W == 1) begin : g_sig1
      assign sig_nxt = (^(sig & SIG_POLY)) ^ rsp_fold;
    end else begin : g_sign
      assign sig_nxt = {sig[SIG_W-2:0], ^(sig & SIG_POLY)} ^ rsp_fold;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state    <= S_IDLE;
      seed_idx <= '0;
      pat_cnt  <= '0;
      lfsr     <= '0;
      sig      <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          state    <= S_LOAD;
          seed_idx <= '0;
          sig      <= '0;
          done_q   <= 1'b0;
          match_q  <= 1'b0;
        end
        S_LOAD: begin
          lfsr    <= seed_fix;
          pat_cnt <= '0;
          state   <= S_RUN;
        end
        S_RUN: begin
          lfsr    <= lfsr_nxt;
          sig     <= sig_nxt;
          pat_cnt <= pat_cnt + CNT_W'(1);
          if (pat_cnt == LAST_PAT) begin
            if (seed_idx == LAST_SEED) begin
              state   <= S_IDLE;
              done_q  <= 1'b1;
              match_q <= (sig_nxt == GOLDEN);
            end else begin
              seed_idx <= seed_idx + SEED_AW'(1);
              state    <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pat_o     = lfsr;
  assign pat_vld_o = (state == S_RUN);
  assign done_o    = done_q;
  assign pass_o    = done_q & match_q;
  assign fail_o    = done_q & ~match_q;
endmodule

// File: rtl/bist_reseed_chk.sv
module bist_reseed_chk #(
  parameter int PAT_W = 8,
  parameter logic [PAT_W-1:0] PAT_POLY = PAT_W'(8'hB8)
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [PAT_W-1:0] pat_o,
  input logic             pat_vld_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             fail_o,
  input logic             seed_rd
);
  logic [PAT_W-1:0] exp_step;
  assign exp_step = {pat_o[PAT_W-2:0], ^(pat_o & PAT_POLY)};

  a_r1_load_no_pattern: assert property (@(posedge clk_i) disable iff (rst_i)
    seed_rd |-> !pat_vld_o && !done_o);
  a_r2_lfsr_step: assert property (@(posedge clk_i) disable iff (rst_i)
    pat_vld_o && $past(pat_vld_o) |-> pat_o == $past(exp_step));
  a_r3_no_zero_pattern: assert property (@(posedge clk_i) disable iff (rst_i)
    pat_vld_o |-> pat_o != '0);
  a_r5_verdict_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (pass_o ^ fail_o));
  a_r5_done_after_pattern: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(done_o) |-> $past(pat_vld_o));
  a_r6_start_in_load_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    seed_rd && start_i |=> pat_vld_o);
  a_r7_reset_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !pat_vld_o && !done_o && !pass_o && !fail_o);
endmodule

bind bist_reseed_ctrl bist_reseed_chk #(.PAT_W(PAT_W), .PAT_POLY(PAT_POLY)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .pat_o(pat_o),
  .pat_vld_o(pat_vld_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
  .seed_rd(seed_rd)
);

// File: tb/sim_bist_reseed_ctrl.sv
module sim_bist_reseed_ctrl;
  localparam int PW = 8, RW = 8, SW = 4, NS = 4, PPS = 16;
  localparam logic [PW-1:0] PPOLY = 8'hB8;
  localparam logic [SW-1:0] SPOLY = 4'h9;
  localparam logic [NS*PW-1:0] TAB = 32'h5A00C301;

  function automatic logic [PW-1:0] pstep(input logic [PW-1:0] p);
    return {p[PW-2:0], ^(p & PPOLY)};
  endfunction
  function automatic logic [RW-1:0] uut(input logic [PW-1:0] p);
    return {p[3:0], p[7:4]} ^ (p + 8'h35);
  endfunction
  function automatic logic [SW-1:0] sstep(input logic [SW-1:0] s, input logic [RW-1:0] r);
    return {s[SW-2:0], ^(s & SPOLY)} ^ (r[7:4] ^ r[3:0]);
  endfunction
  function automatic logic [PW-1:0] fix(input logic [PW-1:0] s);
    return (s == '0) ? '1 : s;
  endfunction
  function automatic logic [SW-1:0] calc_golden();
    logic [SW-1:0] s;
    logic [PW-1:0] m;
    s = '0;
    for (int i = 0; i < NS; i++) begin
      m = fix(TAB[i*PW +: PW]);
      for (int k = 0; k < PPS; k++) begin
        s = sstep(s, uut(m));
        m = pstep(m);
      end
    end
    return s;
  endfunction
  localparam logic [SW-1:0] GOLD = calc_golden();

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, inj = 1'b0;
  logic [PW-1:0] pat;
  logic [RW-1:0] rsp;
  logic vld, done, pass, fail;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;
  assign rsp = uut(pat) ^ {{(RW-1){1'b0}}, inj};

  bist_reseed_ctrl #(.PAT_W(PW), .RSP_W(RW), .SIG_W(SW), .N_SEEDS(NS),
    .PATS_PER_SEED(PPS), .PAT_POLY(PPOLY), .SIG_POLY(SPOLY), .SEED_TAB(TAB),
    .GOLDEN(GOLD)) u0 (
    .clk_i(clk), .rst_i(rst), .start_i(start), .rsp_i(rsp), .pat_o(pat),
    .pat_vld_o(vld), .done_o(done), .pass_o(pass), .fail_o(fail));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int mid_start_c, input int inject_v);
    logic [PW-1:0] m;
    logic [SW-1:0] es;
    int v;
    bit exp_pass;
    m = '0; es = '0; v = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < NS*(PPS+1); c++) begin
      int idx, k;
      idx = c / (PPS+1);
      k = c % (PPS+1);
      if (c == mid_start_c) start = 1'b1;
      chk(!done && !pass && !fail, "R5 status clear during run", {done, pass, fail}, 0);
      if (k == 0) begin
        chk(!vld, "R1 load cycle has no pattern", vld, 0);
        m = fix(TAB[idx*PW +: PW]);
      end else begin
        chk(vld, "R1 pattern cycle valid", vld, 1);
        if (idx == 2) chk(pat == m, "R3 zero seed replaced", pat, m);
        else          chk(pat == m, "R2 pattern sequence", pat, m);
        inj = (v == inject_v);
        es = sstep(es, uut(m) ^ {{(RW-1){1'b0}}, inj});
        m = pstep(m);
        v++;
      end
      @(negedge clk); start = 1'b0; inj = 1'b0;
    end
    exp_pass = (es == GOLD);
    chk(done && !vld, "R5 done after last pattern", {done, vld}, 2'b10);
    chk(pass == exp_pass && fail == !exp_pass, "R4 R5 verdict", {pass, fail}, {exp_pass, !exp_pass});
    repeat (4) @(negedge clk);
    chk(done && pass == exp_pass && !vld, "R5 verdict held", {done, pass, vld}, {1'b1, exp_pass, 1'b0});
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk(!vld && !done && !pass && !fail, "R7 state under reset", {vld, done, pass, fail}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!vld && !done, "R7 idle without start", {vld, done}, 0);
  endtask

  task automatic t_clean_run();
    run_seq(-1, -1);
    chk(pass == 1'b1, "R4 clean run matches golden", pass, 1);
  endtask

  task automatic t_fault_run();
    run_seq(-1, 23);
    chk(fail == 1'b1 && pass == 1'b0, "R4 corrupted response fails", {pass, fail}, 2'b01);
  endtask

  task automatic t_start_ignored();
    run_seq(5, -1);
    chk(pass == 1'b1, "R6 start in pattern cycle ignored", pass, 1);
    run_seq(17, -1);
    chk(pass == 1'b1, "R6 start in load cycle ignored", pass, 1);
  endtask

  task automatic t_mid_reset();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!vld && !done && !pass && !fail, "R7 reset aborts run", {vld, done, pass, fail}, 0);
    repeat (4) @(negedge clk);
    chk(!vld && !done, "R7 stays idle after reset", {vld, done}, 0);
    run_seq(-1, -1);
    chk(pass == 1'b1, "R7 run after reset passes", pass, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_clean_run();
    t_fault_run();
    t_clean_run();
    t_start_ignored();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule